// File: doc/BRIEF.md
# USB Device Interrupt Status and Enable Registers

This block holds the interrupt status of a USB function controller. It latches a small set of single-cycle events into sticky flag bits: endpoint-information load complete, start-of-frame, Set_Configuration seen and Set_Interface seen. It also sets a flag on every change of the bus suspend level, in either direction. Beside the flags sits an enable register. The single interrupt request line is the OR of every flag that is both set and enabled.

Software uses a small register port with an address, a write strobe, write data and combinational read data. The flag register clears only the bits written as 0, so firmware can acknowledge one source without racing the others. The start-of-frame flag cannot be cleared from this port. It is cleared by a dedicated acknowledge pulse. One extra bit mirrors the live suspend level and never requests an interrupt.

Top module: `usbif_irq_status`

## Requirements
- R1: After reset every flag bit, the enable register, `rd_data` at both addresses and `irq` are 0.
- R2: A pulse on `ep_load_done`, `set_cfg_seen` or `set_intf_seen` sets flag bit 3, 1 or 0 respectively at the next clock edge. The bit then stays 1 until it is cleared.
- R3: A write to address 0 clears each of flag bits 4, 3, 1 and 0 whose `wr_data` bit is 0. Flag bits written as 1 keep their value.
- R4: If an event and a clearing write hit the same flag bit in the same cycle, the bit is 1 after that edge.
- R5: Flag bit 4 is set at the edge where the sampled `bus_suspended` differs from its value at the previous edge. This applies to both rising and falling changes. The reference value after reset is 0.
- R6: Bit 5 at address 0 reads the current `bus_suspended` level with no register delay. It never contributes to `irq`.
- R7: Flag bit 2 is set by `sof_seen` and is not changed by any write. A `sof_ack` pulse clears it. If `sof_seen` and `sof_ack` are high in the same cycle, the bit becomes 1.
- R8: Bits 7 and 6 at address 0 always read 0, and writes to them have no effect.
- R9: Address 1 is the enable register. Bits 4..0 are written from `wr_data` and read back; bits 7..5 read 0. A write to one address never changes the other register.
- R10: `irq` is 1 exactly when some flag bit among 4..0 and the same enable bit are both 1. It follows the registered state without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register select: 0 flags, 1 enables |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| ep_load_done | input | 1 | Pulse: endpoint information load finished |
| sof_seen | input | 1 | Pulse: start-of-frame detected |
| sof_ack | input | 1 | Pulse: clear the start-of-frame flag |
| set_cfg_seen | input | 1 | Pulse: Set_Configuration request detected |
| set_intf_seen | input | 1 | Pulse: Set_Interface request detected |
| bus_suspended | input | 1 | Level: 1 while the bus is suspended |
| irq | output | 1 | Interrupt request |

## Verification
An event pulse, a clearing write, an enable write or a change of the suspend level is sampled at one clock edge. The resulting flag, enable and `irq` values are due right after that same edge. The live suspend bit and the read mux respond with no register at all. The bench drives every input at the falling edge and settles for 1 ns. It then compares `rd_data` and `irq` against a reference model, which it advances by exactly one step per falling edge. This way each result is checked in the half-cycle after the edge that produced it. Directed sequences put the event-versus-clear and event-versus-acknowledge collisions and both suspend directions into single cycles, and a seeded random run follows them.

// File: rtl/usbif_pkg.sv
package usbif_pkg;

    localparam int REG_W     = 8;
    localparam int NFLAG     = 5;

    localparam int FLG_INTF     = 0;
    localparam int FLG_CFG      = 1;
    localparam int FLG_SOF      = 2;
    localparam int FLG_EP_LOAD  = 3;
    localparam int FLG_SUSP_CHG = 4;
    localparam int BIT_SUSP_LIV = 5;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } flag_state_t;

    typedef struct packed {
        logic [NFLAG-1:0] en;
    } en_state_t;

    typedef struct packed {
        logic prev;
    } susp_state_t;

endpackage

// File: rtl/usbif_susp_track.sv
module usbif_susp_track
    import usbif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic susp_in,
    output logic susp_change
);

    susp_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = susp_in;
        susp_change = susp_in ^ st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SUSP_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        susp_change |=> (st_q.prev == $past(susp_in)))          // R5
        else $error("suspend reference not updated");

endmodule

// File: rtl/usbif_flag_bank.sv
module usbif_flag_bank
    import usbif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_data,
    input  logic             sof_ack,
    output logic [NFLAG-1:0] flags
);

    flag_state_t st_d, st_q;
    logic [NFLAG-1:0] keep;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLAG; i++) begin
            if (i == FLG_SOF) keep[i] = ~sof_ack;
            else              keep[i] = ~(clr_we & ~clr_data[i]);
            st_d.flags[i] = evt[i] | (st_q.flags[i] & keep[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[FLG_EP_LOAD] |=> flags[FLG_EP_LOAD])               // R2
        else $error("event did not set flag");

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[FLG_CFG] && clr_we && !clr_data[FLG_CFG]) |=> flags[FLG_CFG]) // R4
        else $error("clear won over event");

    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_INTF] && !(clr_we && !clr_data[FLG_INTF])) |=> flags[FLG_INTF]) // R3
        else $error("flag lost without clear");

    AST_SOF_WRITE_PROOF: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_SOF] && !sof_ack) |=> flags[FLG_SOF])       // R7
        else $error("sof flag cleared without ack");

endmodule

// File: rtl/usbif_enable_reg.sv
module usbif_enable_reg
    import usbif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NFLAG-1:0] wdata,
    output logic [NFLAG-1:0] en
);

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en))                                    // R9
        else $error("enable changed without write");

endmodule

// File: rtl/usbif_irq_status.sv
module usbif_irq_status
    import usbif_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int ADDR_FLAG = 0,
    parameter int ADDR_EN   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ep_load_done,
    input  logic              sof_seen,
    input  logic              sof_ack,
    input  logic              set_cfg_seen,
    input  logic              set_intf_seen,
    input  logic              bus_suspended,
    output logic              irq
);

    localparam int PAD_W = REG_W - NFLAG - 1;
    localparam int EPAD  = REG_W - NFLAG;

    logic             susp_change;
    logic [NFLAG-1:0] evt;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] en;
    logic             sel_flag, sel_en;
    logic             unused_wr_hi;

    assign sel_flag     = (addr == ADDR_W'(ADDR_FLAG));
    assign sel_en       = (addr == ADDR_W'(ADDR_EN));
    assign unused_wr_hi = ^wr_data[REG_W-1:NFLAG];

    always_comb begin
        evt               = '0;
        evt[FLG_INTF]     = set_intf_seen;
        evt[FLG_CFG]      = set_cfg_seen;
        evt[FLG_SOF]      = sof_seen;
        evt[FLG_EP_LOAD]  = ep_load_done;
        evt[FLG_SUSP_CHG] = susp_change;
    end

    usbif_susp_track u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .susp_in     (bus_suspended),
        .susp_change (susp_change)
    );

    usbif_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (wr_en & sel_flag),
        .clr_data (wr_data[NFLAG-1:0]),
        .sof_ack  (sof_ack),
        .flags    (flags)
    );

    usbif_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en & sel_en),
        .wdata (wr_data[NFLAG-1:0]),
        .en    (en)
    );

    always_comb begin
        rd_data = '0;
        if (sel_flag)    rd_data = {{PAD_W{1'b0}}, bus_suspended, flags};
        else if (sel_en) rd_data = {{EPAD{1'b0}}, en};
    end

    assign irq = |(flags & en);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:BIT_SUSP_LIV+1] == '0)                 // R8
        else $error("reserved bits nonzero");

    AST_SUSP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        sel_flag |-> (rd_data[BIT_SUSP_LIV] == bus_suspended))  // R6
        else $error("live suspend bit mismatch");

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0 || en == '0) |-> !irq)                     // R10
        else $error("irq without enabled flag");

endmodule

// File: tb/usbif_irq_status_tb.sv
module usbif_irq_status_tb;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       addr = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       ep_load_done = 0, sof_seen = 0, sof_ack = 0;
    logic       set_cfg_seen = 0, set_intf_seen = 0, bus_suspended = 0;
    logic       irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [4:0] m_flags = 0, m_en = 0;
    logic       m_prev = 0;

    always #4 clk = ~clk;

    usbif_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ep_load_done(ep_load_done),
        .sof_seen(sof_seen), .sof_ack(sof_ack), .set_cfg_seen(set_cfg_seen),
        .set_intf_seen(set_intf_seen), .bus_suspended(bus_suspended), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(logic a, logic [4:0] f, logic [4:0] e, logic s);
        return a ? {3'b000, e} : {2'b00, s, f};
    endfunction

    function automatic logic exp_irq(logic [4:0] f, logic [4:0] e);
        return |(f & e);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, check settled outputs, then advance model one edge.
    task automatic cyc(string req, logic a, logic w, logic [7:0] d,
                       logic epl, logic sof, logic ack, logic cfg, logic intf, logic susp);
        logic [4:0] keep;
        logic       tog;
        addr = a; wr_en = w; wr_data = d; ep_load_done = epl; sof_seen = sof;
        sof_ack = ack; set_cfg_seen = cfg; set_intf_seen = intf; bus_suspended = susp;
        #1;
        chk(req, rd_data, exp_rd(a, m_flags, m_en, susp));
        chk("R10", {7'd0, irq}, {7'd0, exp_irq(m_flags, m_en)});
        keep = (w && !a) ? d[4:0] : 5'h1F;
        keep[2] = ~ack;
        tog = susp ^ m_prev;
        @(negedge clk);
        m_flags = {tog, epl, sof, cfg, intf} | (m_flags & keep);
        if (w && a) m_en = d[4:0];
        m_prev = susp;
    endtask

    task automatic idle(string req, logic a, logic susp);
        cyc(req, a, 0, 8'h00, 0, 0, 0, 0, 0, susp);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        #1;
        chk("R1", rd_data, 8'h00);
        chk("R1", {7'd0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        idle("R1", 1, 0);
        idle("R1", 0, 0);
        // R2: events set their flags and hold
        cyc("R2", 0, 0, 0, 1, 0, 0, 1, 1, 0);
        idle("R2", 0, 0);
        chk("R2", rd_data, 8'h0B);
        // R3: write 0 to bit1 only
        cyc("R3", 0, 1, 8'hFD, 0, 0, 0, 0, 0, 0);
        idle("R3", 0, 0);
        chk("R3", rd_data, 8'h09);
        // R4: clear and event together on bit0
        cyc("R4", 0, 1, 8'h00, 0, 0, 0, 0, 1, 0);
        idle("R4", 0, 0);
        chk("R4", rd_data, 8'h01);
        // R5: both directions; R6 live bit
        cyc("R5", 0, 1, 8'h00, 0, 0, 0, 0, 0, 1);
        idle("R6", 0, 1);
        chk("R5", rd_data, 8'h30);
        cyc("R5", 0, 1, 8'hEF, 0, 0, 0, 0, 0, 1);
        idle("R5", 0, 1);
        chk("R5", rd_data, 8'h20);
        idle("R5", 0, 0);
        idle("R5", 0, 0);
        chk("R5", rd_data, 8'h10);
        cyc("R5", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        // R6: suspend bit never raises irq even with all enables
        cyc("R9", 1, 1, 8'hFF, 0, 0, 0, 0, 0, 1);
        idle("R9", 1, 1);
        chk("R9", rd_data, 8'h1F);
        cyc("R6", 0, 1, 8'h00, 0, 0, 0, 0, 0, 1);
        idle("R6", 0, 1);
        chk("R6", {7'd0, irq}, 8'h00);
        chk("R6", rd_data, 8'h20);
        idle("R6", 0, 0);
        cyc("R6", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        // R7: sof write-proof, ack clears, set beats ack
        cyc("R7", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc("R7", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        idle("R7", 0, 0);
        chk("R7", rd_data, 8'h04);
        chk("R10", {7'd0, irq}, 8'h01);
        cyc("R7", 0, 0, 0, 0, 0, 1, 0, 0, 0);
        idle("R7", 0, 0);
        chk("R7", rd_data, 8'h00);
        cyc("R7", 0, 0, 0, 0, 1, 1, 0, 0, 0);
        idle("R7", 0, 0);
        chk("R7", rd_data, 8'h04);
        // R8: reserved bits
        cyc("R8", 0, 1, 8'hC4, 0, 0, 0, 0, 0, 0);
        idle("R8", 0, 0);
        chk("R8", rd_data, 8'h04);
        // R9/R10: mask off sof, irq drops; enable write leaves flags
        cyc("R9", 1, 1, 8'hFB, 0, 0, 0, 0, 0, 0);
        idle("R10", 1, 0);
        chk("R10", {7'd0, irq}, 8'h00);
        idle("R9", 0, 0);
        chk("R9", rd_data, 8'h04);
        // random run
        for (int i = 0; i < 3000; i++) begin
            logic a, w;
            logic [7:0] d;
            a = 1'($urandom);
            w = ($urandom % 4) == 0;
            d = 8'($urandom);
            cyc(a ? "R9" : "R3", a, w, d,
                ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 5) == 0,
                ($urandom % 6) == 0, ($urandom % 6) == 0,
                (($urandom % 8) == 0) ? ~bus_suspended : bus_suspended);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule